// File: doc/BRIEF.md
# Six-Pin Configurable GPIO Port

This block is a small memory-mapped general-purpose I/O port serving six pads. Software reaches it through a plain synchronous register bus carrying an address, a write strobe, write data and combinational read data. Three registers sit behind that bus: a mode register, a level register and a read-only sampled-pin register. For every pin the block drives an output enable, an output level and a weak pull-up enable toward the pad, and it takes the raw pad level back in.

Each pin's mode bit and level bit together pick one of four behaviours. A mode bit of 1 makes the pin a push-pull driver at the level bit's value. A mode bit of 0 makes the pin an input, and in that case the level bit chooses between a floating input and a weakly pulled-up input. Pin 3 is an input with pull-up whatever the registers contain. Pad levels come in through a two-stage synchronizer before software can read them.

Top module: `gpio6_port`

## Requirements
- R1: After reset the mode register (address 0) and level register (address 1) read 0, no pin drives (pad_oe = 0), and only pin 3 has its pull-up enabled (pad_pu = 6'b001000).
- R2: Writes to address 0 or 1 store data bits 5:0, which map to pins 5:0; bits 7:6 are not stored and always read back as 0.
- R3: A pin whose mode bit is 1 (other than pin 3) has pad_oe = 1 and pad_out equal to its level bit; any pin with pad_oe = 0 has pad_out = 0.
- R4: A pin whose mode bit is 0 and level bit is 0 (other than pin 3) is a floating input: pad_oe = 0 and pad_pu = 0.
- R5: A pin whose mode bit is 0 and level bit is 1 (other than pin 3) is a pulled-up input: pad_oe = 0 and pad_pu = 1.
- R6: Pin 3 always has pad_oe = 0 and pad_pu = 1, whatever its mode and level bits hold.
- R7: Reading address 2 returns pad_in in bits 5:0 and 0 in bits 7:6, for every pin regardless of its mode; a pad change is visible after the second rising clock edge following it, and not after the first.
- R8: Address 2 is read-only: a write there changes neither the mode nor the level register nor the value read at address 2.
- R9: pad_oe and pad_pu are never both 1 on the same pin.
- R10: Address 3 always reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 mode, 1 level, 2 sampled pins, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 6 | Raw pad levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin driven level |
| pad_pu | output | 6 | Per-pin weak pull-up enable |

## Verification
On every cycle the assertions guard the exclusion of pull-up and drive, the fixed state of pin 3, the zero upper read bits and the silent unused address, the two-clock lag of the sampled-pin read, and the output enables that follow a mode-register write. The bench scenarios are what show the four pin modes arising from particular mode and level combinations, the mixed configurations, the exact edge at which a pad change appears in a read, and that writes to the read-only and unused addresses leave the stored registers intact.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;

    localparam int NUM_PINS  = 6;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 2;
    localparam int FIXED_PIN = 3;

    localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PINS  = 2'd2;

    typedef enum logic [1:0] {
        PIN_FLOAT  = 2'd0,
        PIN_PULLUP = 2'd1,
        PIN_DRIVE0 = 2'd2,
        PIN_DRIVE1 = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/gpio6_regs.sv
module gpio6_regs
    import gpio6_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] mode_q,
    output logic [NPINS-1:0] level_q
);

    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] level;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            if (addr == ADDR_MODE)  regs_d.mode  = wdata;
            if (addr == ADDR_LEVEL) regs_d.level = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mode_q  = regs_q.mode;
    assign level_q = regs_q.level;

endmodule

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.stage1 = raw;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign synced = sync_q.stage2;

endmodule

// File: rtl/gpio6_pin_mode.sv
module gpio6_pin_mode
    import gpio6_pkg::*;
#(
    parameter bit IS_FIXED = 1'b0
) (
    input  logic mode_bit,
    input  logic level_bit,
    output logic oe,
    output logic out,
    output logic pu
);

    pin_mode_e mode;

    generate
        if (IS_FIXED) begin : g_fixed
            logic unused_bits;
            assign unused_bits = mode_bit ^ level_bit;
            assign mode = PIN_PULLUP;
        end else begin : g_cfg
            always_comb begin
                unique case ({mode_bit, level_bit})
                    2'b00:   mode = PIN_FLOAT;
                    2'b01:   mode = PIN_PULLUP;
                    2'b10:   mode = PIN_DRIVE0;
                    default: mode = PIN_DRIVE1;
                endcase
            end
        end
    endgenerate

    always_comb begin
        oe  = 1'b0;
        out = 1'b0;
        pu  = 1'b0;
        case (mode)
            PIN_PULLUP: pu = 1'b1;
            PIN_DRIVE0: oe = 1'b1;
            PIN_DRIVE1: begin
                oe  = 1'b1;
                out = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int RW    = REG_W,
    parameter int AW    = ADDR_W,
    parameter int FIXED = FIXED_PIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [RW-1:0]    bus_wdata,
    output logic [RW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu
);

    logic [NPINS-1:0] mode_q;
    logic [NPINS-1:0] level_q;
    logic [NPINS-1:0] pins_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[RW-1:NPINS];

    gpio6_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata[NPINS-1:0]),
        .mode_q  (mode_q),
        .level_q (level_q)
    );

    gpio6_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (pins_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio6_pin_mode #(.IS_FIXED(i == FIXED)) u_pin (
            .mode_bit  (mode_q[i]),
            .level_bit (level_q[i]),
            .oe        (pad_oe[i]),
            .out       (pad_out[i]),
            .pu        (pad_pu[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_MODE:  bus_rdata[NPINS-1:0] = mode_q;
            ADDR_LEVEL: bus_rdata[NPINS-1:0] = level_q;
            ADDR_PINS:  bus_rdata[NPINS-1:0] = pins_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk
    import gpio6_pkg::*;
#(
    parameter int NPINS = NUM_PINS,
    parameter int RW    = REG_W,
    parameter int AW    = ADDR_W,
    parameter int FIXED = FIXED_PIN
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic [RW-1:0]    bus_wdata,
    input logic [RW-1:0]    bus_rdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pu
);

    localparam logic [NPINS-1:0] FIXED_MASK = NPINS'(1) << FIXED;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    p_no_drive_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    p_fixed_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[FIXED] && pad_pu[FIXED]);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[RW-1:NPINS] == '0);

    p_unused_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

    p_pin_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && bus_addr == ADDR_PINS) |->
            (bus_rdata[NPINS-1:0] == $past(pad_in, 2)));

    p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_MODE) |=>
            (pad_oe == ($past(bus_wdata[NPINS-1:0]) & ~FIXED_MASK)));

endmodule

bind gpio6_port gpio6_port_chk #(
    .NPINS(NPINS), .RW(RW), .AW(AW), .FIXED(FIXED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu)
);

// File: tb/gpio6_port_test.sv
module gpio6_port_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_oe;
    logic [5:0] pad_out;
    logic [5:0] pad_pu;

    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    gpio6_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(2'd0, v); check("R1", "mode after reset", v, 8'h00);
        rd_reg(2'd1, v); check("R1", "level after reset", v, 8'h00);
        check("R1", "oe after reset", {2'b0, pad_oe}, 8'h00);
        check("R1", "pu after reset", {2'b0, pad_pu}, 8'h08);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, v); check("R2", "mode readback", v, 8'h3F);
        wr_reg(2'd1, 8'hC5);
        rd_reg(2'd1, v); check("R2", "level readback", v, 8'h05);
    endtask

    task automatic t_all_out;
        wr_reg(2'd0, 8'h3F);
        wr_reg(2'd1, 8'h2A);
        check("R3", "oe all-output", {2'b0, pad_oe}, 8'h37);
        check("R3", "out all-output", {2'b0, pad_out}, 8'h22);
        check("R6", "pu all-output", {2'b0, pad_pu}, 8'h08);
    endtask

    task automatic t_all_in;
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h15);
        check("R5", "pu inputs level 010101", {2'b0, pad_pu}, 8'h1D);
        check("R4", "oe inputs", {2'b0, pad_oe}, 8'h00);
        check("R3", "out idle when not driving", {2'b0, pad_out}, 8'h00);
        wr_reg(2'd1, 8'h00);
        check("R4", "pu floating inputs", {2'b0, pad_pu}, 8'h08);
    endtask

    task automatic t_mixed;
        wr_reg(2'd0, 8'h0F);
        wr_reg(2'd1, 8'h33);
        check("R3", "oe mixed", {2'b0, pad_oe}, 8'h07);
        check("R3", "out mixed", {2'b0, pad_out}, 8'h03);
        check("R5", "pu mixed", {2'b0, pad_pu}, 8'h38);
        check("R9", "oe&pu mixed", {2'b0, pad_oe & pad_pu}, 8'h00);
        check("R6", "pin3 mixed", {6'b0, pad_oe[3], pad_pu[3]}, 8'h01);
    endtask

    task automatic t_pins;
        logic [7:0] v;
        bus_addr = 2'd2;
        @(negedge clk);
        pad_in = 6'h15;
        @(negedge clk);
        rd_reg(2'd2, v); check("R7", "pins after one edge", v, 8'h00);
        @(negedge clk);
        rd_reg(2'd2, v); check("R7", "pins after two edges", v, 8'h15);
        pad_in = 6'h2E;
        @(negedge clk);
        @(negedge clk);
        rd_reg(2'd2, v); check("R7", "pins with outputs set", v, 8'h2E);
    endtask

    task automatic t_readonly;
        logic [7:0] v;
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd0, v); check("R8", "mode after pin write", v, 8'h0F);
        rd_reg(2'd1, v); check("R8", "level after pin write", v, 8'h33);
        rd_reg(2'd2, v); check("R8", "pins after pin write", v, 8'h2E);
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd3, v); check("R10", "unused addr read", v, 8'h00);
        rd_reg(2'd0, v); check("R10", "mode after unused write", v, 8'h0F);
        rd_reg(2'd1, v); check("R10", "level after unused write", v, 8'h33);
    endtask

    initial begin
        #(PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 3 + 2);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_readback;
        t_all_out;
        t_all_in;
        t_mixed;
        t_pins;
        t_readonly;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule